// File: doc/BRIEF.md
# Interrupt Source Controller

This block is the source side of a two-level interrupt system. It watches a parameterized number of interrupt inputs. They are numbered from a fixed base, so the first input carries number `SRC_BASE` and the last carries `SRC_BASE + NUM_SRC - 1`. Software marks each input as level type or message (edge) type. Each source also keeps a destination server, a priority, a saved priority and four status flags. A priority of 0xFF means the source is masked.

When a source is due, the block sends it to a downstream presentation unit as a single-cycle presentation carrying the number, the server and the priority. The presentation unit answers with three kinds of notification. A reject says a presentation was refused. An EOI says the handler has finished. A resend asks for a rescan. The rescan visits one source per cycle. While it runs, `ready_o` is low and new commands and notifications must wait. Presentations that do not come from a rescan go through a fixed arbiter: the lowest index wins and at most one presentation leaves per cycle.

Software configures the block through a command port. There are five commands: set routing, query, interrupt off, interrupt on and set kind. Each accepted command returns one response cycle with an error flag and the source's current server and priority.

Top module: `isc_top`

## Requirements
- R1: A command whose source number lies outside `SRC_BASE .. SRC_BASE+NUM_SRC-1`, or whose op code is not 0..4, returns `rsp_err_o=1` and changes no state. The response appears on the cycle after the command is accepted.
- R2: After reset the following hold:
  - `ready_o` is 1 and no presentation or response is active.
  - Every source is message type, routed to server 0, with priority and saved priority both 0xFF.
- R3: Set routing (op 0) writes the server, the priority and the saved priority. It returns an error and changes nothing when the server is not below `NUM_SERVERS` or the 9-bit priority exceeds 0xFF.
- R4: A message source that fires while masked is not presented; it is marked pending instead. A later set routing or interrupt on that unmasks it presents it exactly once.
- R5: A rising edge on an unmasked message source produces one presentation. It carries number `SRC_BASE+index` and the stored server and priority, and it appears within two cycles.
- R6: A level source is presented when it is asserted, unmasked and not already sent, and presenting it marks it sent. A sent source is not presented again until an EOI arrives; after the EOI it is presented again if it is still asserted.
- R7: A reject sets the source's rejected flag and clears its sent flag. A resend presents each rejected, unmasked message source once and clears the flag, so a second resend presents nothing.
- R8: An EOI addressed to a message source has no effect.
- R9: Interrupt off (op 2) sets the priority to 0xFF and keeps the old priority as the saved one. Interrupt on (op 3) restores the priority from the saved value.
- R10: An accepted resend makes the block hold `ready_o` low for exactly `NUM_SRC` cycles. During that time it visits the sources in ascending order and presents at most one per cycle.
- R11: Sources that become due in the same cycle are presented on consecutive cycles, lowest index first.
- R12: Set kind (op 4) makes a source level type when `cmd_level_i=1` and message type when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Interrupt input lines |
| cmd_valid_i | input | 1 | Command request |
| cmd_op_i | input | 3 | Op: 0 route, 1 query, 2 off, 3 on, 4 kind |
| cmd_num_i | input | NUM_W | Source number for the command |
| cmd_server_i | input | NUM_W | Server for set routing |
| cmd_prio_i | input | PRIO_W+1 | Priority for set routing |
| cmd_level_i | input | 1 | Kind for set kind (1 = level) |
| ready_o | output | 1 | Commands and notifications accepted |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_err_o | output | 1 | Parameter error |
| rsp_server_o | output | SRV_W | Server of the addressed source |
| rsp_prio_o | output | PRIO_W | Priority of the addressed source |
| rej_valid_i | input | 1 | Reject notification |
| rej_num_i | input | NUM_W | Rejected source number |
| eoi_valid_i | input | 1 | EOI notification |
| eoi_num_i | input | NUM_W | Source number that completed |
| resend_i | input | 1 | Resend request |
| pres_valid_o | output | 1 | Presentation strobe |
| pres_num_o | output | NUM_W | Presented source number |
| pres_server_o | output | SRV_W | Presented server |
| pres_prio_o | output | PRIO_W | Presented priority |

## Verification
Several properties are checked on every cycle:
- An out-of-range command number always draws an error response.
- Every response traces back to an accepted command.
- An interrupt off leaves the priority masked.
- A resend always drops `ready_o`.
- No presentation ever carries the masked priority.

The scenarios of the bench are needed for the rules that depend on history. These include the release of a pending source when it is unmasked, the sent-until-EOI rule for level sources, and clearing the rejected flag so that a second resend stays silent. The ordering of simultaneous presentations and the exact length of the rescan also need the bench.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef enum logic [2:0] {
    OP_ROUTE = 3'd0,
    OP_QUERY = 3'd1,
    OP_OFF   = 3'd2,
    OP_ON    = 3'd3,
    OP_KIND  = 3'd4
  } isc_op_e;

  localparam int unsigned PRIO_W = 8;
  localparam logic [PRIO_W-1:0] PRIO_MASKED = '1;
endpackage

// File: rtl/isc_num_check.sv
module isc_num_check #(
  parameter int unsigned NUM_W = 16,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned BASE  = 16,
  parameter int unsigned COUNT = 8
) (
  input  logic [NUM_W-1:0] num_i,
  output logic             ok_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [NUM_W-1:0] off;

  assign off   = num_i - NUM_W'(BASE);
  assign ok_o  = (num_i >= NUM_W'(BASE)) && (off < NUM_W'(COUNT));
  assign idx_o = off[IDX_W-1:0];
endmodule

// File: rtl/isc_pick.sv
module isc_pick #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/isc_top.sv
module isc_top
  import isc_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 8,
  parameter int unsigned SRC_BASE    = 16,
  parameter int unsigned NUM_SERVERS = 4,
  parameter int unsigned NUM_W       = 16,
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int unsigned SRV_W = (NUM_SERVERS > 1) ? $clog2(NUM_SERVERS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               cmd_valid_i,
  input  logic [2:0]         cmd_op_i,
  input  logic [NUM_W-1:0]   cmd_num_i,
  input  logic [NUM_W-1:0]   cmd_server_i,
  input  logic [PRIO_W:0]    cmd_prio_i,
  input  logic               cmd_level_i,
  output logic               ready_o,
  output logic               rsp_valid_o,
  output logic               rsp_err_o,
  output logic [SRV_W-1:0]   rsp_server_o,
  output logic [PRIO_W-1:0]  rsp_prio_o,
  input  logic               rej_valid_i,
  input  logic [NUM_W-1:0]   rej_num_i,
  input  logic               eoi_valid_i,
  input  logic [NUM_W-1:0]   eoi_num_i,
  input  logic               resend_i,
  output logic               pres_valid_o,
  output logic [NUM_W-1:0]   pres_num_o,
  output logic [SRV_W-1:0]   pres_server_o,
  output logic [PRIO_W-1:0]  pres_prio_o
);
  // per-source state
  logic [SRV_W-1:0]  srv_q  [NUM_SRC];
  logic [PRIO_W-1:0] prio_q [NUM_SRC];
  logic [PRIO_W-1:0] save_q [NUM_SRC];
  logic [NUM_SRC-1:0] lvl_q, asrt_q, sent_q, rej_q, mpend_q, queue_q;

  logic             scan_q;
  logic [IDX_W-1:0] scan_idx_q;

  // number decoders for command and notifications
  logic c_ok, r_ok, e_ok;
  logic [IDX_W-1:0] c_idx, r_idx, e_idx;

  isc_num_check #(.NUM_W(NUM_W), .IDX_W(IDX_W), .BASE(SRC_BASE), .COUNT(NUM_SRC))
    u_chk_cmd (.num_i(cmd_num_i), .ok_o(c_ok), .idx_o(c_idx));
  isc_num_check #(.NUM_W(NUM_W), .IDX_W(IDX_W), .BASE(SRC_BASE), .COUNT(NUM_SRC))
    u_chk_rej (.num_i(rej_num_i), .ok_o(r_ok), .idx_o(r_idx));
  isc_num_check #(.NUM_W(NUM_W), .IDX_W(IDX_W), .BASE(SRC_BASE), .COUNT(NUM_SRC))
    u_chk_eoi (.num_i(eoi_num_i), .ok_o(e_ok), .idx_o(e_idx));

  // delivery conditions
  logic [NUM_SRC-1:0] masked, lvl_want, msg_want, want, rise;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign masked[g] = (prio_q[g] == PRIO_MASKED);
  end

  assign lvl_want = lvl_q & asrt_q & ~sent_q & ~masked;
  assign msg_want = ~lvl_q & queue_q & ~masked;
  assign want     = lvl_want | msg_want;
  assign rise     = src_i & ~asrt_q & ~lvl_q;

  logic             pk_found;
  logic [IDX_W-1:0] pk_idx;

  isc_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .req_i(want), .found_o(pk_found), .idx_o(pk_idx)
  );

  // rescan step
  logic scan_lvl_hit, scan_msg_rej, scan_msg_hit, scan_last;
  assign scan_lvl_hit = lvl_q[scan_idx_q] && lvl_want[scan_idx_q];
  assign scan_msg_rej = !lvl_q[scan_idx_q] && rej_q[scan_idx_q];
  assign scan_msg_hit = scan_msg_rej && !masked[scan_idx_q];
  assign scan_last    = (scan_idx_q == IDX_W'(NUM_SRC - 1));

  logic             fire;
  logic [IDX_W-1:0] fire_idx;
  assign fire     = scan_q ? (scan_lvl_hit || scan_msg_hit) : pk_found;
  assign fire_idx = scan_q ? scan_idx_q : pk_idx;

  // command decode
  assign ready_o = !scan_q;

  logic accept, srv_ok, prio_ok, cmd_err, cmd_do;
  isc_op_e op;
  assign op      = isc_op_e'(cmd_op_i);
  assign accept  = cmd_valid_i && ready_o;
  assign srv_ok  = cmd_server_i < NUM_W'(NUM_SERVERS);
  assign prio_ok = !cmd_prio_i[PRIO_W];

  always_comb begin
    unique case (op)
      OP_ROUTE:                   cmd_err = !(c_ok && srv_ok && prio_ok);
      OP_QUERY, OP_OFF, OP_ON,
      OP_KIND:                    cmd_err = !c_ok;
      default:                    cmd_err = 1'b1;
    endcase
  end
  assign cmd_do = accept && !cmd_err;

  // priority written by route / on; used to release a pending message
  logic              prio_wr;
  logic [PRIO_W-1:0] prio_new;
  always_comb begin
    prio_wr  = 1'b0;
    prio_new = cmd_prio_i[PRIO_W-1:0];
    if (cmd_do && op == OP_ROUTE) prio_wr = 1'b1;
    if (cmd_do && op == OP_ON) begin
      prio_wr  = 1'b1;
      prio_new = save_q[c_idx];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        srv_q[i]  <= '0;
        prio_q[i] <= PRIO_MASKED;
        save_q[i] <= PRIO_MASKED;
      end
      lvl_q      <= '0;
      asrt_q     <= '0;
      sent_q     <= '0;
      rej_q      <= '0;
      mpend_q    <= '0;
      queue_q    <= '0;
      scan_q     <= 1'b0;
      scan_idx_q <= '0;
    end else begin
      asrt_q <= src_i;

      // presentation bookkeeping
      if (fire) begin
        if (lvl_q[fire_idx]) sent_q[fire_idx] <= 1'b1;
        else if (!scan_q)    queue_q[fire_idx] <= 1'b0;
      end
      if (scan_q && scan_msg_rej) rej_q[scan_idx_q] <= 1'b0;

      // message edges: queue when unmasked, hold pending when masked
      for (int i = 0; i < NUM_SRC; i++) begin
        if (rise[i]) begin
          if (masked[i]) mpend_q[i] <= 1'b1;
          else           queue_q[i] <= 1'b1;
        end
      end

      if (ready_o && rej_valid_i && r_ok) begin
        rej_q[r_idx]  <= 1'b1;
        sent_q[r_idx] <= 1'b0;
      end
      if (ready_o && eoi_valid_i && e_ok && lvl_q[e_idx]) sent_q[e_idx] <= 1'b0;

      if (cmd_do) begin
        unique case (op)
          OP_ROUTE: begin
            srv_q[c_idx]  <= cmd_server_i[SRV_W-1:0];
            prio_q[c_idx] <= prio_new;
            save_q[c_idx] <= prio_new;
          end
          OP_OFF: begin
            prio_q[c_idx] <= PRIO_MASKED;
            save_q[c_idx] <= prio_q[c_idx];
          end
          OP_ON:   prio_q[c_idx] <= prio_new;
          OP_KIND: lvl_q[c_idx]  <= cmd_level_i;
          default: ;
        endcase
      end
      if (prio_wr && !lvl_q[c_idx] && mpend_q[c_idx] && prio_new != PRIO_MASKED) begin
        mpend_q[c_idx] <= 1'b0;
        queue_q[c_idx] <= 1'b1;
      end

      // rescan sequencing
      if (scan_q) begin
        if (scan_last) scan_q <= 1'b0;
        else           scan_idx_q <= scan_idx_q + 1'b1;
      end else if (resend_i) begin
        scan_q     <= 1'b1;
        scan_idx_q <= '0;
      end
    end
  end

  // output registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pres_valid_o  <= 1'b0;
      pres_num_o    <= '0;
      pres_server_o <= '0;
      pres_prio_o   <= '0;
      rsp_valid_o   <= 1'b0;
      rsp_err_o     <= 1'b0;
      rsp_server_o  <= '0;
      rsp_prio_o    <= '0;
    end else begin
      pres_valid_o  <= fire;
      pres_num_o    <= NUM_W'(SRC_BASE) + NUM_W'(fire_idx);
      pres_server_o <= srv_q[fire_idx];
      pres_prio_o   <= prio_q[fire_idx];
      rsp_valid_o   <= accept;
      rsp_err_o     <= cmd_err;
      rsp_server_o  <= c_ok ? srv_q[c_idx] : '0;
      rsp_prio_o    <= c_ok ? prio_q[c_idx] : PRIO_MASKED;
    end
  end

  // R1
  a_r1_bad_num_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && ready_o && !c_ok) |=> (rsp_valid_o && rsp_err_o));
  // R1
  a_r1_rsp_follows_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(cmd_valid_i && ready_o));
  // R9
  a_r9_off_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && ready_o && cmd_op_i == 3'd2 && c_ok) |=> (prio_q[$past(c_idx)] == PRIO_MASKED));
  // R10
  a_r10_scan_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resend_i && ready_o) |=> !ready_o);
  // R5
  a_r5_pres_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pres_valid_o |-> (pres_prio_o != PRIO_MASKED));
endmodule

// File: tb/tb_isc_top.sv
module tb_isc_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;
  localparam int BASE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [15:0] cmd_num = '0, cmd_srv = '0;
  logic [8:0] cmd_prio = '0;
  logic cmd_lvl = 1'b0;
  logic ready, rsp_valid, rsp_err;
  logic [1:0] rsp_srv;
  logic [7:0] rsp_prio;
  logic rej_valid = 1'b0, eoi_valid = 1'b0, resend = 1'b0;
  logic [15:0] rej_num = '0, eoi_num = '0;
  logic pres_valid;
  logic [15:0] pres_num;
  logic [1:0] pres_srv;
  logic [7:0] pres_prio;

  always #(CLK_PERIOD/2) clk = ~clk;

  isc_top dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_num_i(cmd_num),
    .cmd_server_i(cmd_srv), .cmd_prio_i(cmd_prio), .cmd_level_i(cmd_lvl),
    .ready_o(ready), .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err),
    .rsp_server_o(rsp_srv), .rsp_prio_o(rsp_prio),
    .rej_valid_i(rej_valid), .rej_num_i(rej_num),
    .eoi_valid_i(eoi_valid), .eoi_num_i(eoi_num), .resend_i(resend),
    .pres_valid_o(pres_valid), .pres_num_o(pres_num),
    .pres_server_o(pres_srv), .pres_prio_o(pres_prio)
  );

  int checks = 0, failures = 0;
  int cyc = 0;
  int pcount = 0;
  int log_num [64];
  int log_srv [64];
  int log_prio [64];
  int log_cyc [64];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (pres_valid) begin
      log_num[pcount % 64]  <= int'(pres_num);
      log_srv[pcount % 64]  <= int'(pres_srv);
      log_prio[pcount % 64] <= int'(pres_prio);
      log_cyc[pcount % 64]  <= cyc;
      pcount <= pcount + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_cmd(input logic [2:0] op, input int num, input int srv, input int prio,
                        input logic lvl, output logic err, output int rs, output int rp);
    @(negedge clk);
    while (!ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_num = 16'(num);
    cmd_srv = 16'(srv); cmd_prio = 9'(prio); cmd_lvl = lvl;
    @(negedge clk);
    cmd_valid = 1'b0;
    err = rsp_err; rs = int'(rsp_srv); rp = int'(rsp_prio);
    if (!rsp_valid) begin
      failures++; checks++;
      $display("FAIL R1 response missing actual=0 expected=1");
    end
  endtask

  task automatic pulse_src(input int idx);
    @(negedge clk); src[idx] = 1'b1;
    @(negedge clk); src[idx] = 1'b0;
  endtask

  task automatic send_rej(input int num);
    @(negedge clk); while (!ready) @(negedge clk);
    rej_valid = 1'b1; rej_num = 16'(num);
    @(negedge clk); rej_valid = 1'b0;
  endtask

  task automatic send_eoi(input int num);
    @(negedge clk); while (!ready) @(negedge clk);
    eoi_valid = 1'b1; eoi_num = 16'(num);
    @(negedge clk); eoi_valid = 1'b0;
  endtask

  task automatic send_resend(output int low_cycles);
    @(negedge clk); while (!ready) @(negedge clk);
    resend = 1'b1;
    @(negedge clk); resend = 1'b0;
    low_cycles = 0;
    while (!ready) begin
      low_cycles++;
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] num;
    logic [15:0] srv;
    logic [8:0]  prio;
    logic        err;
    logic [1:0]  esrv;
    logic [7:0]  eprio;
  } vec_t;

  // ops: 0 route, 1 query, 2 off, 3 on, 4 kind
  localparam vec_t VEC [14] = '{
    '{3'd1, 16'd16, 16'd0, 9'd0,     1'b0, 2'd0, 8'hFF}, // R2 reset values
    '{3'd1, 16'd15, 16'd0, 9'd0,     1'b1, 2'd0, 8'h00}, // R1 below base
    '{3'd1, 16'd24, 16'd0, 9'd0,     1'b1, 2'd0, 8'h00}, // R1 above top
    '{3'd0, 16'd17, 16'd2, 9'd5,     1'b0, 2'd0, 8'h00}, // R3 good route
    '{3'd1, 16'd17, 16'd0, 9'd0,     1'b0, 2'd2, 8'd5},  // R3 readback
    '{3'd0, 16'd17, 16'd4, 9'd3,     1'b1, 2'd0, 8'h00}, // R3 bad server
    '{3'd0, 16'd17, 16'd1, 9'h100,   1'b1, 2'd0, 8'h00}, // R3 bad priority
    '{3'd1, 16'd17, 16'd0, 9'd0,     1'b0, 2'd2, 8'd5},  // R3 unchanged
    '{3'd2, 16'd17, 16'd0, 9'd0,     1'b0, 2'd0, 8'h00}, // R9 off
    '{3'd1, 16'd17, 16'd0, 9'd0,     1'b0, 2'd2, 8'hFF}, // R9 masked
    '{3'd3, 16'd17, 16'd0, 9'd0,     1'b0, 2'd0, 8'h00}, // R9 on
    '{3'd1, 16'd17, 16'd0, 9'd0,     1'b0, 2'd2, 8'd5},  // R9 restored
    '{3'd2, 16'd24, 16'd0, 9'd0,     1'b1, 2'd0, 8'h00}, // R1 off out of range
    '{3'd7, 16'd16, 16'd0, 9'd0,     1'b1, 2'd0, 8'h00}  // R1 bad op
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic err;
    int rs, rp, base, low;

    wait_cyc(3);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(1);

    // R2 reset state
    chk(ready == 1'b1, "R2 ready", int'(ready), 1);
    chk(pres_valid == 1'b0, "R2 no presentation", int'(pres_valid), 0);
    chk(rsp_valid == 1'b0, "R2 no response", int'(rsp_valid), 0);

    for (int i = 0; i < 14; i++) begin
      do_cmd(VEC[i].op, int'(VEC[i].num), int'(VEC[i].srv), int'(VEC[i].prio), 1'b0, err, rs, rp);
      chk(err == VEC[i].err, $sformatf("R1/R3 vec%0d err", i), int'(err), int'(VEC[i].err));
      if (VEC[i].op == 3'd1 && !VEC[i].err) begin
        chk(rs == int'(VEC[i].esrv), $sformatf("R2/R9 vec%0d server", i), rs, int'(VEC[i].esrv));
        chk(rp == int'(VEC[i].eprio), $sformatf("R2/R9 vec%0d prio", i), rp, int'(VEC[i].eprio));
      end
    end
    chk(pcount == 0, "R2 no presentation during config", pcount, 0);

    // R5 unmasked message edge
    base = pcount;
    pulse_src(1);
    wait_cyc(3);
    chk(pcount - base == 1, "R5 one presentation", pcount - base, 1);
    chk(log_num[base % 64] == 17, "R5 number", log_num[base % 64], 17);
    chk(log_srv[base % 64] == 2, "R5 server", log_srv[base % 64], 2);
    chk(log_prio[base % 64] == 5, "R5 priority", log_prio[base % 64], 5);

    // R4 masked message held pending, released on unmask
    base = pcount;
    pulse_src(2);
    wait_cyc(4);
    chk(pcount - base == 0, "R4 masked not presented", pcount - base, 0);
    do_cmd(3'd0, 18, 1, 7, 1'b0, err, rs, rp);
    wait_cyc(3);
    chk(pcount - base == 1, "R4 released once", pcount - base, 1);
    chk(log_num[base % 64] == 18 && log_prio[base % 64] == 7, "R4 released number",
        log_num[base % 64], 18);
    do_cmd(3'd0, 18, 1, 6, 1'b0, err, rs, rp);
    wait_cyc(3);
    chk(pcount - base == 1, "R4 pending cleared", pcount - base, 1);

    // R8 / R7 reject, EOI on message, resend
    base = pcount;
    send_rej(17);
    send_eoi(17);
    wait_cyc(3);
    chk(pcount - base == 0, "R8 EOI on message no effect", pcount - base, 0);
    send_resend(low);
    wait_cyc(2);
    chk(low == NSRC, "R10 scan length", low, NSRC);
    chk(pcount - base == 1, "R7 resend re-presents", pcount - base, 1);
    chk(log_num[base % 64] == 17, "R7 resent number", log_num[base % 64], 17);
    send_resend(low);
    wait_cyc(2);
    chk(pcount - base == 1, "R7 rejected flag cleared", pcount - base, 1);

    // R9 pending release through interrupt on
    base = pcount;
    do_cmd(3'd2, 17, 0, 0, 1'b0, err, rs, rp);
    pulse_src(1);
    wait_cyc(3);
    chk(pcount - base == 0, "R9 off blocks presentation", pcount - base, 0);
    do_cmd(3'd3, 17, 0, 0, 1'b0, err, rs, rp);
    wait_cyc(3);
    chk(pcount - base == 1, "R9 on releases pending", pcount - base, 1);
    chk(log_prio[base % 64] == 5, "R9 restored priority", log_prio[base % 64], 5);

    // R12 / R6 level source
    base = pcount;
    do_cmd(3'd4, 19, 0, 0, 1'b1, err, rs, rp);
    chk(err == 1'b0, "R12 kind accepted", int'(err), 0);
    do_cmd(3'd0, 19, 3, 4, 1'b0, err, rs, rp);
    @(negedge clk) src[3] = 1'b1;
    wait_cyc(6);
    chk(pcount - base == 1, "R6 level presented once", pcount - base, 1);
    chk(log_num[base % 64] == 19 && log_srv[base % 64] == 3, "R6 level number",
        log_num[base % 64], 19);
    send_eoi(19);
    wait_cyc(3);
    chk(pcount - base == 2, "R6 EOI re-presents asserted", pcount - base, 2);
    @(negedge clk) src[3] = 1'b0;
    wait_cyc(1);
    send_eoi(19);
    wait_cyc(4);
    chk(pcount - base == 2, "R6 deasserted not presented", pcount - base, 2);

    // R11 simultaneous message edges
    do_cmd(3'd0, 20, 0, 2, 1'b0, err, rs, rp);
    do_cmd(3'd0, 21, 1, 3, 1'b0, err, rs, rp);
    base = pcount;
    @(negedge clk) src[5:4] = 2'b11;
    @(negedge clk) src[5:4] = 2'b00;
    wait_cyc(4);
    chk(pcount - base == 2, "R11 two presentations", pcount - base, 2);
    chk(log_num[base % 64] == 20, "R11 lower first", log_num[base % 64], 20);
    chk(log_num[(base + 1) % 64] == 21, "R11 higher second", log_num[(base + 1) % 64], 21);
    chk(log_cyc[(base + 1) % 64] == log_cyc[base % 64] + 1, "R11 consecutive",
        log_cyc[(base + 1) % 64] - log_cyc[base % 64], 1);

    // R10 scan order with two rejected sources
    base = pcount;
    send_rej(21);
    send_rej(20);
    send_resend(low);
    wait_cyc(2);
    chk(low == NSRC, "R10 ready low cycles", low, NSRC);
    chk(pcount - base == 2, "R10 two resent", pcount - base, 2);
    chk(log_num[base % 64] == 20 && log_num[(base + 1) % 64] == 21, "R10 ascending order",
        log_num[base % 64], 20);
    do_cmd(3'd1, 21, 0, 0, 1'b0, err, rs, rp);
    chk(rs == 1 && rp == 3, "R10 command after scan", rp, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule